// File: doc/BRIEF.md
# Controller Command and Status Register File

This block is the host-facing register file of a descriptor-ring Ethernet controller. The host sees only two 16-bit words. A write to the pointer word picks a register number. Reads and writes of the data word then reach that register until the pointer is changed again. Register 0 is the main status word. It holds command bits, event flags raised by the DMA and MAC logic, an interrupt enable, and two read-only summary bits. The summary bits also drive a level interrupt line.

The remaining registers hold the controller's configuration:
- the two halves of the initialisation-block address;
- a three-bit bus-mode word;
- four multicast filter words;
- a mode word that carries the promiscuous-mode bit.

These registers accept writes only while the controller is stopped. A stop command returns the status word and the bus-mode word to their idle values. The block has no streaming data path. Every port is a plain control or status pin sampled on the rising clock edge, so there is no back-pressure to manage.

Top module: `csr_regfile`

## Requirements
- R1: After reset, the pointer is 0, the status word reads 0x0004 (only the stop bit set), all configuration registers read zero, and `irq` is low.
- R2: A write with `host_sel`=1 loads the pointer from `host_wdata[3:0]`. A read with `host_sel`=1 returns the pointer, zero-extended. A read with `host_sel`=0 returns the selected register. Register numbers with no storage (4–7, 12–14) read as zero and ignore writes.
- R3: In the status word, writing one to bit 0 (init), bit 1 (start) or bit 3 (transmit demand) sets that bit, and writing zero leaves it unchanged. Each such write of one gives a single-cycle pulse on `cmd_init`, `cmd_start` or `cmd_tx_demand`. Writing init or start without stop clears the stop bit.
- R4: Writing one to status bit 2 (stop) sets stop and pulses `cmd_stop`. In the same step it clears bits 0, 1, 3, 4, 5 and 8–14, and clears the bus-mode register. Bit 6 (enable) is kept. Stop wins over init, start or transmit demand written in the same word, and those command pulses are suppressed. For example, writing 0x0045 leaves 0x0044.
- R5: The event flags are bits 8 (init done), 9 (tx done), 10 (rx done), 11 (memory error), 12 (missed frame), 13 (carrier error) and 14 (babble). Each is set by its event input and cleared by writing one to its bit. Writing zero has no effect. Event inputs are ignored while the stop bit is set.
- R6: When an event input and a host write clearing the same flag fall in the same cycle, the flag ends up set.
- R7: Bit 4 (transmitter on) and bit 5 (receiver on) are set by `txon_set` and `rxon_set` while not stopped. Host writes to them have no effect.
- R8: Bit 6 is the interrupt enable. Every status-word write loads it from the written data.
- R9: Bit 15 reads as the OR of bits 11, 12, 13 and 14. Host writes to bit 15 have no effect.
- R10: Bit 7 and `irq` read as bit 6 ANDed with the OR of bits 8, 9, 10, 11, 12 and 14. The carrier-error flag alone raises no interrupt.
- R11: Register 1 (address low), register 2 (address high), register 3 (bus mode, bits 2:0), registers 8–11 (filter words) and register 15 (promiscuous, bit 15 only) can be written only while the stop bit is set. At other times writes to them are ignored. Their contents appear on `init_blk_addr`, `bus_mode`, `mcast_filter` (register 8 in the low word) and `promisc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 1 = pointer word, 0 = data window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the word selected by `host_sel` |
| ev_init_done | input | 1 | Sets init-done flag |
| ev_tx_done | input | 1 | Sets tx-done flag |
| ev_rx_done | input | 1 | Sets rx-done flag |
| ev_mem_err | input | 1 | Sets memory-error flag |
| ev_rx_missed | input | 1 | Sets missed-frame flag |
| ev_carrier_err | input | 1 | Sets carrier-error flag |
| ev_babble | input | 1 | Sets babble flag |
| txon_set | input | 1 | Marks transmitter running |
| rxon_set | input | 1 | Marks receiver running |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_tx_demand | output | 1 | Transmit-demand pulse |
| irq | output | 1 | Level interrupt, active high |
| init_blk_addr | output | 32 | Init-block address {reg2, reg1} |
| bus_mode | output | 3 | Bus-mode bits |
| mcast_filter | output | 64 | Filter words, register 8 lowest |
| promisc | output | 1 | Promiscuous mode |

## Verification
Every status and configuration bit reads back through the data window on the cycle after the edge that changed it. A wrong flag, a lost stop, or a stale enable therefore shows up on `host_rdata` at the first read, with no extra latency. A wrong interrupt summary appears on `irq` in that same cycle. A missed stop reset of the bus mode, or a configuration write that wrongly succeeds, is visible on `bus_mode` and `init_blk_addr` one edge after the offending write. Command pulses last exactly one cycle, so an extra or missing pulse is caught only by sampling right after the write edge.

// File: rtl/csr_rf_pkg.sv
package csr_rf_pkg;
  localparam int unsigned DATA_W = 16;

  // status word bit positions
  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_TXON = 4;
  localparam int unsigned B_RXON = 5;
  localparam int unsigned B_INEA = 6;
  localparam int unsigned B_INTR = 7;
  localparam int unsigned B_EVLO = 8;
  localparam int unsigned B_EVHI = 14;
  localparam int unsigned B_ERR  = 15;

  // register numbers
  localparam int unsigned REG_STAT  = 0;
  localparam int unsigned REG_IB_LO = 1;
  localparam int unsigned REG_IB_HI = 2;
  localparam int unsigned REG_BMODE = 3;
  localparam int unsigned REG_FILT0 = 8;
  localparam int unsigned REG_MODE  = 15;
  localparam int unsigned BMODE_W   = 3;

  // event flags, packed to match status bits 14..8
  typedef struct packed {
    logic babl;
    logic cerr;
    logic miss;
    logic merr;
    logic rint;
    logic tint;
    logic idon;
  } evt_t;
endpackage

// File: rtl/csr_ptr.sv
module csr_ptr #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (wr_en) ptr <= wdata;
  end
endmodule

// File: rtl/csr_status.sv
module csr_status
  import csr_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  evt_t              evt_in,
  input  logic              txon_set,
  input  logic              rxon_set,
  output logic [DATA_W-1:0] status,
  output logic              stopped,
  output logic              stop_hit,
  output logic              p_init,
  output logic              p_strt,
  output logic              p_stop,
  output logic              p_tdmd
);
  logic init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, inea_q;
  evt_t ev_q, ev_clr;
  logic err_sum, intr_sum;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};
  assign stop_hit = wr & wdata[B_STOP];
  assign ev_clr   = wr ? evt_t'(wdata[B_EVHI:B_EVLO]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0; strt_q <= 1'b0; stop_q <= 1'b1; tdmd_q <= 1'b0;
      txon_q <= 1'b0; rxon_q <= 1'b0; inea_q <= 1'b0; ev_q   <= '0;
      p_init <= 1'b0; p_strt <= 1'b0; p_stop <= 1'b0; p_tdmd <= 1'b0;
    end else begin
      p_stop <= stop_hit;
      p_init <= wr & wdata[B_INIT] & ~stop_hit;
      p_strt <= wr & wdata[B_STRT] & ~stop_hit;
      p_tdmd <= wr & wdata[B_TDMD] & ~stop_hit;
      if (wr) inea_q <= wdata[B_INEA];
      if (stop_hit) begin
        stop_q <= 1'b1;
        init_q <= 1'b0; strt_q <= 1'b0; tdmd_q <= 1'b0;
        txon_q <= 1'b0; rxon_q <= 1'b0; ev_q   <= '0;
      end else begin
        if (wr && wdata[B_INIT]) init_q <= 1'b1;
        if (wr && wdata[B_STRT]) strt_q <= 1'b1;
        if (wr && wdata[B_TDMD]) tdmd_q <= 1'b1;
        if (wr && (wdata[B_INIT] || wdata[B_STRT])) stop_q <= 1'b0;
        if (!stop_q) begin
          // a same-cycle event overrides the host clear
          ev_q   <= (ev_q & ~ev_clr) | evt_in;
          txon_q <= txon_q | txon_set;
          rxon_q <= rxon_q | rxon_set;
        end
      end
    end
  end

  assign err_sum  = ev_q.babl | ev_q.cerr | ev_q.miss | ev_q.merr;
  assign intr_sum = inea_q & (ev_q.babl | ev_q.miss | ev_q.merr |
                              ev_q.rint | ev_q.tint | ev_q.idon);
  assign stopped  = stop_q;
  assign status   = {err_sum, ev_q, intr_sum, inea_q, rxon_q, txon_q,
                     tdmd_q, stop_q, strt_q, init_q};

  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (stop_q && !init_q && !strt_q && !tdmd_q &&
                  !txon_q && !rxon_q && ev_q == '0));

  a_r3_start_leaves_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !stop_hit && (wdata[B_INIT] || wdata[B_STRT])) |=> !stop_q);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && !stop_hit && evt_in != '0) |=> ((ev_q & $past(evt_in)) == $past(evt_in)));

  a_r5_stopped_no_events: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr) |=> (ev_q == '0));
endmodule

// File: rtl/csr_cfg.sv
module csr_cfg
  import csr_rf_pkg::*;
#(
  parameter int unsigned PTR_W    = 4,
  parameter int unsigned NUM_FILT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [PTR_W-1:0]           ptr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       stopped,
  input  logic                       stop_hit,
  output logic [2*DATA_W-1:0]        ib_addr,
  output logic [BMODE_W-1:0]         bmode,
  output logic [NUM_FILT*DATA_W-1:0] filt_flat,
  output logic                       promisc,
  output logic [DATA_W-1:0]          rd_data
);
  logic              wr_ok;
  logic [DATA_W-1:0] ib_lo_q, ib_hi_q;
  logic [DATA_W-1:0] filt_q [NUM_FILT];

  assign wr_ok = wr & stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_lo_q <= '0; ib_hi_q <= '0; bmode <= '0; promisc <= 1'b0;
    end else begin
      if (wr_ok && ptr == PTR_W'(REG_IB_LO)) ib_lo_q <= wdata;
      if (wr_ok && ptr == PTR_W'(REG_IB_HI)) ib_hi_q <= wdata;
      if (wr_ok && ptr == PTR_W'(REG_MODE))  promisc <= wdata[DATA_W-1];
      if (stop_hit) bmode <= '0;
      else if (wr_ok && ptr == PTR_W'(REG_BMODE)) bmode <= wdata[BMODE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_q[g] <= '0;
      else if (wr_ok && ptr == PTR_W'(REG_FILT0 + g)) filt_q[g] <= wdata;
    end
    assign filt_flat[g*DATA_W +: DATA_W] = filt_q[g];
  end

  assign ib_addr = {ib_hi_q, ib_lo_q};

  always_comb begin
    rd_data = '0;
    if (ptr == PTR_W'(REG_IB_LO)) rd_data = ib_lo_q;
    if (ptr == PTR_W'(REG_IB_HI)) rd_data = ib_hi_q;
    if (ptr == PTR_W'(REG_BMODE)) rd_data = DATA_W'(bmode);
    if (ptr == PTR_W'(REG_MODE))  rd_data = {promisc, {(DATA_W-1){1'b0}}};
    for (int i = 0; i < NUM_FILT; i++)
      if (ptr == PTR_W'(REG_FILT0 + i)) rd_data = filt_q[i];
  end

  a_r11_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !stopped && ptr != PTR_W'(REG_STAT)) |=>
      ($stable(ib_addr) && $stable(filt_flat) && $stable(promisc) && $stable(bmode)));
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_rf_pkg::*;
#(
  parameter int unsigned PTR_W    = 4,
  parameter int unsigned NUM_FILT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic                       host_sel,
  input  logic [15:0]                host_wdata,
  output logic [15:0]                host_rdata,
  input  logic                       ev_init_done,
  input  logic                       ev_tx_done,
  input  logic                       ev_rx_done,
  input  logic                       ev_mem_err,
  input  logic                       ev_rx_missed,
  input  logic                       ev_carrier_err,
  input  logic                       ev_babble,
  input  logic                       txon_set,
  input  logic                       rxon_set,
  output logic                       cmd_init,
  output logic                       cmd_start,
  output logic                       cmd_stop,
  output logic                       cmd_tx_demand,
  output logic                       irq,
  output logic [31:0]                init_blk_addr,
  output logic [2:0]                 bus_mode,
  output logic [NUM_FILT*16-1:0]     mcast_filter,
  output logic                       promisc
);
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] status, cfg_rd;
  logic              stopped, stop_hit, win_wr, stat_wr;
  evt_t              evt;

  assign win_wr  = host_wr & ~host_sel;
  assign stat_wr = win_wr & (ptr == PTR_W'(REG_STAT));
  assign evt = '{babl: ev_babble, cerr: ev_carrier_err, miss: ev_rx_missed,
                 merr: ev_mem_err, rint: ev_rx_done, tint: ev_tx_done,
                 idon: ev_init_done};

  csr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr & host_sel),
    .wdata(host_wdata[PTR_W-1:0]), .ptr(ptr)
  );

  csr_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr(stat_wr), .wdata(host_wdata),
    .evt_in(evt), .txon_set(txon_set), .rxon_set(rxon_set),
    .status(status), .stopped(stopped), .stop_hit(stop_hit),
    .p_init(cmd_init), .p_strt(cmd_start), .p_stop(cmd_stop), .p_tdmd(cmd_tx_demand)
  );

  csr_cfg #(.PTR_W(PTR_W), .NUM_FILT(NUM_FILT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(win_wr), .ptr(ptr), .wdata(host_wdata),
    .stopped(stopped), .stop_hit(stop_hit), .ib_addr(init_blk_addr),
    .bmode(bus_mode), .filt_flat(mcast_filter), .promisc(promisc), .rd_data(cfg_rd)
  );

  assign irq = status[B_INTR];

  always_comb begin
    if (host_sel)                        host_rdata = DATA_W'(ptr);
    else if (ptr == PTR_W'(REG_STAT))    host_rdata = status;
    else                                 host_rdata = cfg_rd;
  end

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[B_INEA]);

  a_r4_stop_pulse_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> !(cmd_init || cmd_start || cmd_tx_demand));
endmodule

// File: tb/csr_regfile_tb.sv
`timescale 1ns/1ps
module csr_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_sel = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic [6:0] evv = 0; // {babble,carrier,missed,mem,rx,tx,initdone}
  logic txs = 0, rxs = 0;
  logic c_init, c_start, c_stop, c_tdmd, irq, promisc;
  logic [31:0] ib;
  logic [2:0] bm;
  logic [63:0] filt;
  logic mon_req = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  int kind_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  csr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_init_done(evv[0]), .ev_tx_done(evv[1]), .ev_rx_done(evv[2]),
    .ev_mem_err(evv[3]), .ev_rx_missed(evv[4]), .ev_carrier_err(evv[5]),
    .ev_babble(evv[6]), .txon_set(txs), .rxon_set(rxs),
    .cmd_init(c_init), .cmd_start(c_start), .cmd_stop(c_stop),
    .cmd_tx_demand(c_tdmd), .irq(irq), .init_blk_addr(ib), .bus_mode(bm),
    .mcast_filter(filt), .promisc(promisc)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      logic [15:0] got, e;
      int k;
      string t;
      e = exp_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
      case (k)
        0: got = host_rdata;
        1: got = {15'b0, irq};
        2: got = {12'b0, c_tdmd, c_stop, c_start, c_init};
        3: got = {13'b0, bm};
        default: got = {15'b0, promisc};
      endcase
      n_chk++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, got, e);
      end
    end
  end

  task automatic drive(input logic wr, input logic sel, input logic [15:0] d,
                       input logic [6:0] ev, input logic tx, input logic rx);
    @(posedge clk); #1;
    mon_req = 0; host_wr = wr; host_sel = sel; host_wdata = d;
    evv = ev; txs = tx; rxs = rx;
  endtask

  task automatic wptr(input logic [15:0] p); drive(1, 1, p, 0, 0, 0); endtask
  task automatic wwin(input logic [15:0] d); drive(1, 0, d, 0, 0, 0); endtask
  task automatic evt(input logic [6:0] v);   drive(0, 0, 0, v, 0, 0); endtask

  task automatic chk(input int kind, input logic sel, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    host_wr = 0; host_sel = sel; host_wdata = 0; evv = 0; txs = 0; rxs = 0;
    exp_q.push_back(e); kind_q.push_back(kind); tag_q.push_back(t);
    mon_req = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(0, 0, 16'h0004, "R1 status after reset");
    chk(0, 1, 16'h0000, "R1 pointer after reset");
    chk(1, 0, 16'h0000, "R1 irq after reset");
    chk(3, 0, 16'h0000, "R1 bus mode after reset");

    // configuration while stopped (R11)
    wptr(1);  wwin(16'h1234);
    wptr(2);  wwin(16'hABCD);
    wptr(3);  wwin(16'hFFFF);
    wptr(8);  wwin(16'hA5A5);
    wptr(11); wwin(16'h5A5A);
    wptr(15); wwin(16'hFFFF);
    wptr(1);  chk(0, 0, 16'h1234, "R11 addr low");
    wptr(2);  chk(0, 0, 16'hABCD, "R11 addr high");
    chk(0, 1, 16'h0002, "R2 pointer readback");
    wptr(3);  chk(0, 0, 16'h0007, "R11 bus mode reg");
    wptr(8);  chk(0, 0, 16'hA5A5, "R11 filter 0");
    wptr(11); chk(0, 0, 16'h5A5A, "R11 filter 3");
    wptr(15); chk(0, 0, 16'h8000, "R11 mode reg");
    wptr(5);  wwin(16'hFFFF); chk(0, 0, 16'h0000, "R2 unused register");
    chk(3, 0, 16'h0007, "R11 bus mode port");
    chk(4, 0, 16'h0001, "R11 promisc port");
    if (ib !== 32'hABCD1234 || filt[15:0] !== 16'hA5A5 || filt[63:48] !== 16'h5A5A) begin
      n_fail++; $display("FAIL R11 outputs: got %h %h expected abcd1234 5a5aa5a5", ib, filt);
    end
    n_chk++;

    // commands (R3)
    wptr(0); wwin(16'h0041);
    chk(2, 0, 16'h0001, "R3 init pulse");
    chk(0, 0, 16'h0041, "R3 init set stop cleared");
    chk(2, 0, 16'h0000, "R3 pulse single cycle");
    wptr(1); wwin(16'h5555); chk(0, 0, 16'h1234, "R11 locked while running");
    wptr(3); wwin(16'h0000); chk(3, 0, 16'h0007, "R11 bus mode locked");
    wptr(0);

    // events (R5, R10)
    evt(7'h02); chk(0, 0, 16'h02C1, "R5 tx done flag");
    chk(1, 0, 16'h0001, "R10 irq on tx done");
    wwin(16'h0240); chk(0, 0, 16'h0041, "R5 write one clears");
    chk(1, 0, 16'h0000, "R10 irq drops");
    wwin(16'h0040); chk(0, 0, 16'h0041, "R3 zero write keeps init");
    drive(1, 0, 16'h0440, 7'h04, 0, 0); chk(0, 0, 16'h04C1, "R6 event beats clear");
    wwin(16'h0440); chk(0, 0, 16'h0041, "R5 rx flag cleared");
    evt(7'h20); chk(0, 0, 16'hA041, "R9 carrier sets err");
    chk(1, 0, 16'h0000, "R10 carrier no irq");
    wwin(16'h8040); chk(0, 0, 16'hA041, "R9 err not writable");
    wwin(16'h2040); chk(0, 0, 16'h0041, "R9 err follows flags");
    wwin(16'h0000); chk(0, 0, 16'h0001, "R8 enable cleared");
    evt(7'h08); chk(0, 0, 16'h8801, "R10 mem err masked");
    chk(1, 0, 16'h0000, "R10 irq masked");
    wwin(16'h0040); chk(0, 0, 16'h88C1, "R8 enable set");
    chk(1, 0, 16'h0001, "R10 irq unmasked");
    wwin(16'h0840); chk(0, 0, 16'h0041, "R5 mem err cleared");

    // running bits (R7)
    wwin(16'h0070); chk(0, 0, 16'h0041, "R7 host cannot set txon");
    drive(0, 0, 0, 0, 1, 1); chk(0, 0, 16'h0071, "R7 txon rxon set");
    wwin(16'h0040); chk(0, 0, 16'h0071, "R7 host cannot clear");
    wwin(16'h004A);
    chk(2, 0, 16'h000A, "R3 start and demand pulses");
    chk(0, 0, 16'h007B, "R3 start and demand set");

    // stop (R4)
    drive(1, 0, 16'h0045, 7'h01, 0, 0);
    chk(2, 0, 16'h0004, "R4 only stop pulse");
    chk(0, 0, 16'h0044, "R4 stop wins");
    chk(3, 0, 16'h0000, "R4 bus mode cleared");
    chk(1, 0, 16'h0000, "R4 irq low after stop");
    drive(0, 0, 0, 7'h02, 1, 0); chk(0, 0, 16'h0044, "R5 events ignored when stopped");
    wptr(3); wwin(16'h0004); chk(0, 0, 16'h0004, "R11 writable after stop");
    chk(3, 0, 16'h0004, "R11 bus mode port after stop");
    wptr(0); chk(0, 0, 16'h0044, "R2 window back on status");

    chk(1, 0, 16'h0000, "R1 final idle");
    @(posedge clk); #1 mon_req = 0;
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule